// File: doc/BRIEF.md
# Speculative Line Alias-Check Tracker

This block sits beside the data cache of a core that runs compiler-placed atomic regions. It reads a decoded stream of memory operations and keeps two marks for each touched 64-byte line: a read mark that only marking loads set, and a write mark that every store in the region sets. A checked store names the marks it must not find on its line. If it finds one, the alias assumption that let the compiler move code is broken. The block then pulses an abort and presents the safe-version PC that was latched when the region began.

The marks live in a small, fully associative table of line tags. It stands in for the speculative tags of the first-level cache. An entry is in use while either of its marks is set, so clearing the last mark frees the entry. A region that needs a new entry while the table is full is aborted. The region is either idle or active. Operations are sampled on a rising clock edge, and every result shows up on the outputs after that same edge.

States: `ST_IDLE` (no region) and `ST_ACTIVE` (region open). Transitions: begin (`ST_IDLE` to `ST_ACTIVE`, PC latched), commit (end, `ST_ACTIVE` to `ST_IDLE`, marks cleared), rollback (abort operation, failed check or table overflow, `ST_ACTIVE` to `ST_IDLE`, marks cleared, abort pulse).

Top module: `spec_alias_tracker`

## Requirements
- R1: An address maps to its line by dropping address bits [5:0]. Addresses that differ only in those bits share marks, and addresses in different 64-byte lines do not.
- R2: A plain load (op code 4) never sets a read mark, so a later read-checked store to that line does not abort.
- R3: A marking load (op code 5) sets the read mark of its line. A later store checked against read marks (op code 8) to that line aborts.
- R4: Clearing the read mark (op code 6) resets only the read mark of the line and leaves its write mark set.
- R5: Every store inside a region sets the write mark of its line. This covers the plain store (op code 7) and the checked stores (op codes 8, 9 and 10).
- R6: A checked store aborts on a set read mark with op code 8, on a set write mark with op code 9, and on either mark with op code 10. A mark the store does not check never causes an abort.
- R7: A checked store compares against the marks as they stood before its own write mark is set. The first write-checked store to a fresh line therefore does not abort.
- R8: Begin (op code 1) latches `op_pc`. On any abort, `abort_pulse` is high for exactly one cycle, starting after the edge that sampled the operation, and `redirect_pc` equals the latched PC in that cycle.
- R9: An explicit abort operation (op code 3) in an active region causes the abort pulse.
- R10: End (op code 2) commits without an abort, drops `region_active`, and leaves no mark set for the next region.
- R11: After an abort, all marks are cleared and the block is idle, with `region_active` low.
- R12: The table holds 16 lines. An operation that needs a 17th entry aborts the region. Clearing the only mark of a line frees its entry.
- R13: In the idle state, every operation except begin is ignored and never aborts. A begin inside an active region is ignored and does not re-latch the PC. Op codes 0 and 11 to 15 do nothing.
- R14: `region_active` is high exactly while a region is open, from the edge that samples begin until the edge that samples its end or abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code (see requirements) |
| op_addr | input | 32 | Byte address of the memory operation |
| op_pc | input | 32 | Safe-version PC, used by begin |
| abort_pulse | output | 1 | One-cycle rollback indication |
| redirect_pc | output | 32 | Safe-version PC, valid while abort_pulse is high |
| region_active | output | 1 | An atomic region is open |

## Verification
Every result is registered once: an operation sampled on a rising edge affects `abort_pulse`, `redirect_pc` and `region_active` right after that edge, and the abort pulse is low again after the following edge. The bench drives each operation on a falling edge and compares the outputs on the next falling edge against a line-mark model, so each comparison lands in the one cycle where the result is due. The bench then checks the following operation's sample for the pulse's return to low.

// File: rtl/sat_pkg.sv
package sat_pkg;

    typedef enum logic [3:0] {
        OP_NOP          = 4'd0,
        OP_BEGIN        = 4'd1,
        OP_END          = 4'd2,
        OP_ABORT        = 4'd3,
        OP_LOAD         = 4'd4,
        OP_LOAD_MARK    = 4'd5,
        OP_CLEAR_MARK   = 4'd6,
        OP_STORE        = 4'd7,
        OP_STORE_CHK_R  = 4'd8,
        OP_STORE_CHK_W  = 4'd9,
        OP_STORE_CHK_RW = 4'd10
    } mem_op_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } region_state_e;

endpackage

// File: rtl/sat_line_table.sv
module sat_line_table #(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] lookup_tag,
    input  logic             clear_all,
    input  logic             set_rd,
    input  logic             set_wr,
    input  logic             clr_rd,
    output logic             hit,
    output logic             hit_rd,
    output logic             hit_wr,
    output logic             full,
    output logic             empty
);

    logic [ENTRIES-1:0] rd_mark;
    logic [ENTRIES-1:0] wr_mark;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [ENTRIES-1:0] in_use;
    logic [ENTRIES-1:0] match;
    logic [ENTRIES-1:0] alloc_oh;
    logic               alloc_req;

    assign in_use    = rd_mark | wr_mark;
    assign hit       = |match;
    assign hit_rd    = |(match & rd_mark);
    assign hit_wr    = |(match & wr_mark);
    assign full      = &in_use;
    assign empty     = ~|in_use;
    assign alloc_req = (set_rd | set_wr) & ~hit & ~full;

    // lowest free entry receives a new line
    always_comb begin
        logic found;
        found    = 1'b0;
        alloc_oh = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!in_use[i] && !found) begin
                alloc_oh[i] = 1'b1;
                found       = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        assign match[g] = in_use[g] && (tag_q[g] == lookup_tag);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_mark[g] <= 1'b0;
                wr_mark[g] <= 1'b0;
                tag_q[g]   <= '0;
            end else if (clear_all) begin
                rd_mark[g] <= 1'b0;
                wr_mark[g] <= 1'b0;
            end else if (match[g]) begin
                if (set_rd) rd_mark[g] <= 1'b1;
                if (clr_rd) rd_mark[g] <= 1'b0;
                if (set_wr) wr_mark[g] <= 1'b1;
            end else if (alloc_req && alloc_oh[g]) begin
                tag_q[g]   <= lookup_tag;
                rd_mark[g] <= set_rd;
                wr_mark[g] <= set_wr;
            end
        end
    end

    // R1: a line tag never occupies two entries
    assert_unique_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(match) <= 1);

    // R11: a clear leaves no mark behind
    assert_clear_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> empty);

endmodule

// File: rtl/sat_region_ctrl.sv
module sat_region_ctrl
    import sat_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [3:0]      op_code,
    input  logic [PC_W-1:0] op_pc,
    input  logic            hit,
    input  logic            hit_rd,
    input  logic            hit_wr,
    input  logic            full,
    output logic            clear_all,
    output logic            set_rd,
    output logic            set_wr,
    output logic            clr_rd,
    output logic            abort_q,
    output logic [PC_W-1:0] safe_pc_q,
    output logic            active
);

    region_state_e state_q, state_d;
    mem_op_e       op;
    logic          live, is_store, chk_rd, chk_wr;
    logic          alias_fail, overflow, abort_req, commit;

    assign op     = mem_op_e'(op_code);
    assign active = (state_q == ST_ACTIVE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            abort_q   <= 1'b0;
            safe_pc_q <= '0;
        end else begin
            state_q <= state_d;
            abort_q <= abort_req;
            if (state_q == ST_IDLE && op_valid && op == OP_BEGIN)
                safe_pc_q <= op_pc;
        end
    end

    // decode, transitions and table commands
    always_comb begin
        live     = op_valid && (state_q == ST_ACTIVE);
        is_store = 1'b0;
        chk_rd   = 1'b0;
        chk_wr   = 1'b0;
        unique case (op)
            OP_STORE:        is_store = 1'b1;
            OP_STORE_CHK_R:  begin is_store = 1'b1; chk_rd = 1'b1; end
            OP_STORE_CHK_W:  begin is_store = 1'b1; chk_wr = 1'b1; end
            OP_STORE_CHK_RW: begin is_store = 1'b1; chk_rd = 1'b1; chk_wr = 1'b1; end
            default:         ;
        endcase

        alias_fail = hit && ((chk_rd && hit_rd) || (chk_wr && hit_wr));
        overflow   = !hit && full && (is_store || op == OP_LOAD_MARK);
        abort_req  = live && (op == OP_ABORT || alias_fail || overflow);
        commit     = live && (op == OP_END);

        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (op_valid && op == OP_BEGIN) state_d = ST_ACTIVE;
            ST_ACTIVE: if (abort_req || commit)        state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase

        clear_all = abort_req || commit;
        set_rd    = live && !abort_req && (op == OP_LOAD_MARK);
        set_wr    = live && !abort_req && is_store;
        clr_rd    = live && (op == OP_CLEAR_MARK);
    end

    // R8: the rollback indication lasts one cycle
    assert_abort_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_q |=> !abort_q);

    // R13: only an open region can roll back
    assert_abort_needs_region_R13: assert property (@(posedge clk) disable iff (!rst_n)
        abort_q |-> $past(state_q == ST_ACTIVE));

    // R3: a read-checked store hitting a read mark rolls back
    assert_read_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (live && chk_rd && hit_rd) |=> (abort_q && state_q == ST_IDLE));

    // R8: the PC does not move while a region is open
    assert_pc_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> $stable(safe_pc_q));

endmodule

// File: rtl/spec_alias_tracker.sv
module spec_alias_tracker
    import sat_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PC_W       = 32,
    parameter int ENTRIES    = 16,
    parameter int LINE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [PC_W-1:0]   op_pc,
    output logic              abort_pulse,
    output logic [PC_W-1:0]   redirect_pc,
    output logic              region_active
);

    localparam int LINE_BITS = $clog2(LINE_BYTES);
    localparam int TAG_W     = ADDR_W - LINE_BITS;

    logic hit, hit_rd, hit_wr, full, empty;
    logic clear_all, set_rd, set_wr, clr_rd;

    sat_region_ctrl #(.PC_W(PC_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .op_pc     (op_pc),
        .hit       (hit),
        .hit_rd    (hit_rd),
        .hit_wr    (hit_wr),
        .full      (full),
        .clear_all (clear_all),
        .set_rd    (set_rd),
        .set_wr    (set_wr),
        .clr_rd    (clr_rd),
        .abort_q   (abort_pulse),
        .safe_pc_q (redirect_pc),
        .active    (region_active)
    );

    sat_line_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .lookup_tag (op_addr[ADDR_W-1:LINE_BITS]),
        .clear_all  (clear_all),
        .set_rd     (set_rd),
        .set_wr     (set_wr),
        .clr_rd     (clr_rd),
        .hit        (hit),
        .hit_rd     (hit_rd),
        .hit_wr     (hit_wr),
        .full       (full),
        .empty      (empty)
    );

    // R11: a rollback leaves the block idle with no marks
    assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> (!region_active && empty));

    // R10: no region open means no marks held
    assert_idle_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !region_active |-> empty);

endmodule

// File: tb/spec_alias_tracker_test.sv
module spec_alias_tracker_test;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic [31:0] op_addr = '0;
    logic [31:0] op_pc = '0;
    logic        abort_pulse;
    logic [31:0] redirect_pc;
    logic        region_active;

    int checks = 0;
    int fails  = 0;

    // model state
    bit          m_act = 0;
    logic [31:0] m_pc = '0;
    logic [25:0] m_tag [N];
    bit          m_rd [N];
    bit          m_wr [N];

    always #2 clk = ~clk;

    spec_alias_tracker uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_addr(op_addr), .op_pc(op_pc), .abort_pulse(abort_pulse),
        .redirect_pc(redirect_pc), .region_active(region_active)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic void model_clear();
        for (int i = 0; i < N; i++) begin
            m_rd[i] = 0;
            m_wr[i] = 0;
        end
    endfunction

    function automatic bit model_step(input int op, input logic [31:0] a, input logic [31:0] pc);
        bit ab = 0;
        int h = -1;
        int fr = -1;
        logic [25:0] ln = a[31:6];
        if (!m_act) begin
            if (op == 1) begin m_act = 1; m_pc = pc; end
            return 0;
        end
        for (int i = 0; i < N; i++) begin
            if ((m_rd[i] || m_wr[i]) && m_tag[i] == ln) h = i;
            if (!(m_rd[i] || m_wr[i]) && fr < 0) fr = i;
        end
        case (op)
            2: begin model_clear(); m_act = 0; end
            3: ab = 1;
            5: if (h >= 0) m_rd[h] = 1;
               else if (fr >= 0) begin m_tag[fr] = ln; m_rd[fr] = 1; m_wr[fr] = 0; end
               else ab = 1;
            6: if (h >= 0) m_rd[h] = 0;
            7, 8, 9, 10: begin
                if (h >= 0) begin
                    if ((op == 8 || op == 10) && m_rd[h]) ab = 1;
                    if ((op == 9 || op == 10) && m_wr[h]) ab = 1;
                    if (!ab) m_wr[h] = 1;
                end else if (fr >= 0) begin
                    m_tag[fr] = ln; m_rd[fr] = 0; m_wr[fr] = 1;
                end else ab = 1;
            end
            default: ;
        endcase
        if (ab) begin model_clear(); m_act = 0; end
        return ab;
    endfunction

    // drive on a falling edge, compare on the next falling edge
    task automatic step(input string tag, input int op, input logic [31:0] a, input logic [31:0] pc);
        bit ab;
        op_valid = 1'b1;
        op_code  = op[3:0];
        op_addr  = a;
        op_pc    = pc;
        ab = model_step(op, a, pc);
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        chk({tag, " abort"}, {31'd0, abort_pulse}, {31'd0, ab});
        chk({tag, " active R14"}, {31'd0, region_active}, {31'd0, m_act});
        if (ab) chk({tag, " redirect R8"}, redirect_pc, m_pc);
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("reset abort R11", {31'd0, abort_pulse}, 32'd0);
        chk("reset active R14", {31'd0, region_active}, 32'd0);

        // R3 and R8
        step("R8 begin", 1, 0, 32'h1000);
        step("R3 mark", 5, 32'h40, 0);
        step("R3 chk_r hit", 8, 32'h48, 0);
        step("R8 pulse ends", 0, 0, 0);
        chk("R8 one cycle", {31'd0, abort_pulse}, 32'd0);
        // R11: marks gone after abort
        step("R11 begin", 1, 0, 32'h2000);
        step("R11 chk_rw old line", 10, 32'h40, 0);
        // R2
        step("R2 load", 4, 32'h80, 0);
        step("R2 chk_r", 8, 32'h80, 0);
        // R1
        step("R1 store", 7, 32'h100, 0);
        step("R1 chk_w next line", 9, 32'h140, 0);
        step("R1 chk_w same line", 9, 32'h13F, 0);
        // R5 and R7
        step("R7 begin", 1, 0, 32'h2100);
        step("R7 first chk_r", 8, 32'h200, 0);
        step("R5 chk_w after checked store", 9, 32'h200, 0);
        // R4
        step("R4 begin", 1, 0, 32'h2200);
        step("R4 mark", 5, 32'h300, 0);
        step("R4 store", 7, 32'h300, 0);
        step("R4 clear", 6, 32'h300, 0);
        step("R4 chk_r after clear", 8, 32'h300, 0);
        step("R4 chk_w keeps write", 9, 32'h300, 0);
        // R6
        step("R6 begin", 1, 0, 32'h2300);
        step("R6 mark", 5, 32'h400, 0);
        step("R6 chk_w ignores read", 9, 32'h400, 0);
        step("R6 mark2", 5, 32'h500, 0);
        step("R6 chk_rw read", 10, 32'h500, 0);
        // R9
        step("R9 begin", 1, 0, 32'h2400);
        step("R9 abort op", 3, 0, 0);
        // R10
        step("R10 begin", 1, 0, 32'h2500);
        step("R10 mark", 5, 32'h600, 0);
        step("R10 end", 2, 0, 0);
        step("R10 begin again", 1, 0, 32'h2600);
        step("R10 chk_rw old line", 10, 32'h600, 0);
        step("R10 end2", 2, 0, 0);
        // R13
        step("R13 idle mark", 5, 32'h700, 0);
        step("R13 idle chk_rw", 10, 32'h700, 0);
        step("R13 idle abort", 3, 0, 0);
        step("R13 idle end", 2, 0, 0);
        step("R13 begin", 1, 0, 32'h3000);
        step("R13 nested begin", 1, 0, 32'h4000);
        step("R13 odd code", 13, 32'h700, 0);
        step("R13 abort keeps first pc", 3, 0, 0);
        // R12
        step("R12 begin", 1, 0, 32'h5000);
        for (int i = 0; i < N; i++) step("R12 fill", 5, 32'h10000 + i * 64, 0);
        step("R12 clear frees", 6, 32'h10000, 0);
        step("R12 reuse", 5, 32'h20000, 0);
        step("R12 overflow", 7, 32'h30000, 0);

        // random mix over a pool larger than the table
        for (int n = 0; n < 3000; n++) begin
            int r = $urandom_range(0, 99);
            int op;
            logic [31:0] a;
            if (!m_act)      op = (r < 70) ? 1 : $urandom_range(0, 15);
            else if (r < 2)  op = 2;
            else if (r < 3)  op = 3;
            else if (r < 4)  op = 1;
            else             op = $urandom_range(4, 10);
            a = ($urandom_range(0, 23) << 6) | $urandom_range(0, 63);
            step("R6 random", op, a, $urandom);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule